// File: doc/BRIEF.md
# Sequential Bus Trigger Analyzer

This block watches a processor bus passively, taking one captured cycle per clock when `smp_valid_i` is high. Each capture is 80 channels wide: a 32-bit address, a 32-bit data word and 16 status bits. The capture is tested against eight programmable event comparators. Each comparator checks address, data and status, and each of those fields has its own value, a per-bit don't-care mask and an enable.

A sequencer of up to eight levels works through a "find A, then B, then C" search. Every level names one event, or the external cross-trigger input, and a number of occurrences to wait for. One inclusive range comparator can be tied to the address or the data field and gates exactly one chosen level. When the last level completes, the analyzer triggers and pulses its cross-trigger output.

After the trigger, the following cycles go into a 256-entry circular trace buffer. Either every cycle is stored or only the cycles that hit a chosen qualifier event. Each entry carries a saturating time tag counted in 40 ns ticks from the trigger. Storage stops when a programmed number of entries has been written, and a done flag is raised. A re-arm command starts a new measurement and keeps the configuration.

Top module: `bus_trig_analyzer`

## Requirements
- R1: An event matches a valid cycle when every enabled field equals its value on all bits whose don't-care mask bit is 0. Enable bit 0 covers address, bit 1 data and bit 2 status. An event with no field enabled matches every valid cycle.
- R2: The sequencer starts at level 0 and moves on only when the current level's source has been seen the programmed number of times. Hits for later levels are ignored until then. When the level numbered by the last-level register completes, `trig_o` rises after that cycle's clock edge. `level_o` shows the current level.
- R3: When enabled, the range comparator requires low ≤ value ≤ high, both bounds inclusive. The value is the address (field bit 0) or the data (field bit 1). It applies only at its programmed level.
- R4: A level whose select bit 3 is set advances on `xtrig_i` instead of an event. `xtrig_o` is a one-cycle pulse in the first cycle that `trig_o` is high.
- R5: Storage begins with the first valid cycle after the triggering cycle. Store mode bit 0 = 0 stores every valid cycle. Mode 1 stores only cycles that hit the qualifier event.
- R6: An entry's time tag is floor(k / TICK_DIV), where k is the number of clocks between the trigger edge and the storing edge (k = 0 for the next edge). TICK_DIV = 2 at 50 MHz gives 40 ns ticks. The tag saturates at its maximum.
- R7: Once `stored_o` equals the programmed post-trigger count, `done_o` is high and no further cycle is stored.
- R8: A level write with a zero occurrence count is ignored and sets `cfg_err_o`. An accepted level write clears `cfg_err_o`.
- R9: `rearm_i` returns the block to level 0, untriggered, with zero stored entries and `done_o` low. The configuration is kept.
- R10: After reset, `trig_o`, `xtrig_o`, `done_o`, `cfg_err_o`, `level_o` and `stored_o` are all zero.

Register map (byte-free word addresses):
- Events: event e at 8e+f. Field f is 0 address value, 1 address mask, 2 data value, 3 data mask, 4 status value, 5 status mask, 6 enables.
- Levels: level j at 0x40+j, with source [3:0] and count [15:8]. The reset value is source j, count 1.
- Control: 0x48 last level [2:0]. 0x49 range low. 0x4A range high. 0x4B range control: enable [0], field [1], level [6:4]. 0x4C store control: mode [0], qualifier [6:4], post count [16:8], reset 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Captured bus cycle present |
| smp_addr_i | input | 32 | Captured address |
| smp_data_i | input | 32 | Captured data |
| smp_stat_i | input | 16 | Captured status |
| xtrig_i | input | 1 | External cross-trigger in |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| rearm_i | input | 1 | Synchronous re-arm |
| rd_idx_i | input | 8 | Trace entry index |
| trig_o | output | 1 | Triggered |
| xtrig_o | output | 1 | Cross-trigger out pulse |
| done_o | output | 1 | Post-trigger storage complete |
| cfg_err_o | output | 1 | Last level write rejected |
| level_o | output | 3 | Current sequence level |
| stored_o | output | 9 | Entries stored since trigger |
| rd_addr_o | output | 32 | Entry address |
| rd_data_o | output | 32 | Entry data |
| rd_stat_o | output | 16 | Entry status |
| rd_tag_o | output | TAG_W | Entry time tag |

## Verification
A configuration write takes effect on the cycle after its strobe. A sample presented in cycle n changes `level_o` and `trig_o` right after edge n, and `xtrig_o` is high during that same following cycle. A stored entry shows on the read port, and in `stored_o` and `done_o`, right after the edge that took its sample. The bench drives every input on the falling edge and reads the outputs on the next falling edge, so each check falls in the first cycle a result is due. Tag expectations count clocks from the trigger edge.

// File: rtl/bta_pkg.sv
package bta_pkg;
  // event register field offsets
  localparam int unsigned F_AVAL = 0;
  localparam int unsigned F_AMSK = 1;
  localparam int unsigned F_DVAL = 2;
  localparam int unsigned F_DMSK = 3;
  localparam int unsigned F_SVAL = 4;
  localparam int unsigned F_SMSK = 5;
  localparam int unsigned F_EN   = 6;
  // control registers, offset from control base
  localparam int unsigned C_LAST = 0;
  localparam int unsigned C_RLO  = 1;
  localparam int unsigned C_RHI  = 2;
  localparam int unsigned C_RCTL = 3;
  localparam int unsigned C_SCTL = 4;
  // bit positions inside level / range / store words
  localparam int unsigned LVL_CNT_LSB = 8;
  localparam int unsigned RNG_LVL_LSB = 4;
  localparam int unsigned STO_Q_LSB   = 4;
  localparam int unsigned STO_N_LSB   = 8;

  typedef enum logic {RNG_ADDR = 1'b0, RNG_DATA = 1'b1} rng_field_e;
  typedef enum logic {STO_ALL = 1'b0, STO_QUAL = 1'b1} sto_mode_e;
endpackage

// File: rtl/bta_evt_cmp.sv
module bta_evt_cmp #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [ADDR_W-1:0] a_val_i,
  input  logic [ADDR_W-1:0] a_dc_i,
  input  logic [DATA_W-1:0] d_val_i,
  input  logic [DATA_W-1:0] d_dc_i,
  input  logic [STAT_W-1:0] s_val_i,
  input  logic [STAT_W-1:0] s_dc_i,
  input  logic [2:0]        en_i,
  output logic              hit_o
);
  logic a_ok, d_ok, s_ok;
  assign a_ok  = ~en_i[0] | (((addr_i ^ a_val_i) & ~a_dc_i) == '0);
  assign d_ok  = ~en_i[1] | (((data_i ^ d_val_i) & ~d_dc_i) == '0);
  assign s_ok  = ~en_i[2] | (((stat_i ^ s_val_i) & ~s_dc_i) == '0);
  assign hit_o = a_ok & d_ok & s_ok;
endmodule

// File: rtl/bta_seq.sv
module bta_seq #(
  parameter int N_LVL  = 8,
  parameter int CNT_W  = 8,
  parameter int LVL_IW = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rearm_i,
  input  logic [N_LVL-1:0]             lvl_hit_i,
  input  logic [N_LVL-1:0][CNT_W-1:0]  lvl_cnt_i,
  input  logic [LVL_IW-1:0]            last_i,
  output logic [LVL_IW-1:0]            lvl_o,
  output logic                         trig_o,
  output logic                         fire_o,
  output logic                         pulse_o
);
  logic [LVL_IW-1:0] lvl_q;
  logic [CNT_W-1:0]  occ_q;
  logic              trig_q, pulse_q;
  logic              hit, lvl_full;

  assign hit      = lvl_hit_i[lvl_q];
  assign lvl_full = (occ_q + CNT_W'(1)) == lvl_cnt_i[lvl_q];
  assign fire_o   = ~trig_q & ~rearm_i & hit & lvl_full & (lvl_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= '0;
      occ_q   <= '0;
      trig_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire_o;
      if (rearm_i) begin
        lvl_q  <= '0;
        occ_q  <= '0;
        trig_q <= 1'b0;
      end else if (!trig_q && hit) begin
        if (lvl_full) begin
          occ_q <= '0;
          if (lvl_q == last_i) trig_q <= 1'b1;
          else                 lvl_q  <= lvl_q + LVL_IW'(1);
        end else begin
          occ_q <= occ_q + CNT_W'(1);
        end
      end
    end
  end

  assign lvl_o   = lvl_q;
  assign trig_o  = trig_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/bta_trace.sv
module bta_trace #(
  parameter int ENT_W    = 80,
  parameter int DEPTH    = 256,
  parameter int TAG_W    = 32,
  parameter int TICK_DIV = 2,
  parameter int PTR_W    = 8,
  parameter int SCNT_W   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rearm_i,
  input  logic              fire_i,
  input  logic              run_i,
  input  logic              wr_i,
  input  logic [ENT_W-1:0]  ent_i,
  input  logic [SCNT_W-1:0] post_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [ENT_W-1:0]  rd_ent_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [SCNT_W-1:0] cnt_o,
  output logic              done_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [ENT_W+TAG_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp_q;
  logic [SCNT_W-1:0] cnt_q;
  logic [TAG_W-1:0]  tag_q;
  logic [PRE_W-1:0]  pre_q;
  logic              we;

  assign done_o = run_i & (cnt_q == post_i);
  assign we     = run_i & ~done_o & wr_i & ~rearm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      cnt_q <= '0;
      tag_q <= '0;
      pre_q <= '0;
    end else if (rearm_i || fire_i) begin
      wp_q  <= '0;
      cnt_q <= '0;
      tag_q <= '0;
      pre_q <= '0;
    end else begin
      if (run_i) begin
        if (pre_q == PRE_W'(TICK_DIV - 1)) begin
          pre_q <= '0;
          if (tag_q != '1) tag_q <= tag_q + TAG_W'(1);
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end
      if (we) begin
        wp_q  <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
        cnt_q <= cnt_q + SCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (we) mem[wp_q] <= {ent_i, tag_q};
  end

  assign {rd_ent_o, rd_tag_o} = mem[rd_idx_i];
  assign cnt_o = cnt_q;
endmodule

// File: rtl/bus_trig_analyzer.sv
module bus_trig_analyzer
  import bta_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 16,
  parameter int N_EVT    = 8,
  parameter int N_LVL    = 8,
  parameter int DEPTH    = 256,
  parameter int TAG_W    = 32,
  parameter int TICK_DIV = 2,
  parameter int CNT_W    = 8,
  parameter int CFG_AW   = 8,
  parameter int CFG_DW   = 32,
  parameter int EVT_IW   = $clog2(N_EVT),
  parameter int LVL_IW   = $clog2(N_LVL),
  parameter int PTR_W    = $clog2(DEPTH),
  parameter int SCNT_W   = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [ADDR_W-1:0] smp_addr_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic [STAT_W-1:0] smp_stat_i,
  input  logic              xtrig_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic              rearm_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic              trig_o,
  output logic              xtrig_o,
  output logic              done_o,
  output logic              cfg_err_o,
  output logic [LVL_IW-1:0] level_o,
  output logic [SCNT_W-1:0] stored_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [STAT_W-1:0] rd_stat_o,
  output logic [TAG_W-1:0]  rd_tag_o
);
  localparam int SEL_W    = EVT_IW + 1;
  localparam int ENT_W    = ADDR_W + DATA_W + STAT_W;
  localparam int LVL_BASE = N_EVT * 8;
  localparam int CTL_BASE = LVL_BASE + N_LVL;

  // event comparator registers
  logic [ADDR_W-1:0] a_val [N_EVT];
  logic [ADDR_W-1:0] a_dc  [N_EVT];
  logic [DATA_W-1:0] d_val [N_EVT];
  logic [DATA_W-1:0] d_dc  [N_EVT];
  logic [STAT_W-1:0] s_val [N_EVT];
  logic [STAT_W-1:0] s_dc  [N_EVT];
  logic [2:0]        ev_en [N_EVT];
  // sequence / range / store registers
  logic [SEL_W-1:0]              lvl_sel [N_LVL];
  logic [N_LVL-1:0][CNT_W-1:0]   lvl_cnt;
  logic [LVL_IW-1:0]             seq_last_q;
  logic [CFG_DW-1:0]             rng_lo_q, rng_hi_q;
  logic                          rng_en_q;
  rng_field_e                    rng_fld_q;
  logic [LVL_IW-1:0]             rng_lvl_q;
  sto_mode_e                     sto_mode_q;
  logic [EVT_IW-1:0]             sto_qual_q;
  logic [SCNT_W-1:0]             sto_post_q;
  logic                          cfg_err_q;

  logic                 is_evt, is_lvl;
  logic [EVT_IW-1:0]    ev_widx;
  logic [2:0]           ev_wfld;
  logic [LVL_IW-1:0]    lv_widx;
  logic [CFG_AW-1:0]    ctl_off;
  logic [CNT_W-1:0]     lv_wcnt;

  assign is_evt  = cfg_addr_i < CFG_AW'(LVL_BASE);
  assign is_lvl  = !is_evt && (cfg_addr_i < CFG_AW'(CTL_BASE));
  assign ev_widx = cfg_addr_i[3 +: EVT_IW];
  assign ev_wfld = cfg_addr_i[2:0];
  assign lv_widx = LVL_IW'(cfg_addr_i - CFG_AW'(LVL_BASE));
  assign ctl_off = cfg_addr_i - CFG_AW'(CTL_BASE);
  assign lv_wcnt = cfg_wdata_i[LVL_CNT_LSB +: CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_EVT; e++) begin
        a_val[e] <= '0; a_dc[e] <= '0;
        d_val[e] <= '0; d_dc[e] <= '0;
        s_val[e] <= '0; s_dc[e] <= '0;
        ev_en[e] <= '0;
      end
      for (int j = 0; j < N_LVL; j++) begin
        lvl_sel[j] <= SEL_W'(j % N_EVT);
        lvl_cnt[j] <= CNT_W'(1);
      end
      seq_last_q <= '0;
      rng_lo_q   <= '0;
      rng_hi_q   <= '0;
      rng_en_q   <= 1'b0;
      rng_fld_q  <= RNG_ADDR;
      rng_lvl_q  <= '0;
      sto_mode_q <= STO_ALL;
      sto_qual_q <= '0;
      sto_post_q <= SCNT_W'(DEPTH);
      cfg_err_q  <= 1'b0;
    end else if (cfg_we_i) begin
      if (is_evt) begin
        case (ev_wfld)
          3'(F_AVAL): a_val[ev_widx] <= cfg_wdata_i[ADDR_W-1:0];
          3'(F_AMSK): a_dc[ev_widx]  <= cfg_wdata_i[ADDR_W-1:0];
          3'(F_DVAL): d_val[ev_widx] <= cfg_wdata_i[DATA_W-1:0];
          3'(F_DMSK): d_dc[ev_widx]  <= cfg_wdata_i[DATA_W-1:0];
          3'(F_SVAL): s_val[ev_widx] <= cfg_wdata_i[STAT_W-1:0];
          3'(F_SMSK): s_dc[ev_widx]  <= cfg_wdata_i[STAT_W-1:0];
          3'(F_EN):   ev_en[ev_widx] <= cfg_wdata_i[2:0];
          default: ;
        endcase
      end else if (is_lvl) begin
        if (lv_wcnt == '0) begin
          cfg_err_q <= 1'b1;   // zero count rejected
        end else begin
          cfg_err_q        <= 1'b0;
          lvl_sel[lv_widx] <= cfg_wdata_i[SEL_W-1:0];
          lvl_cnt[lv_widx] <= lv_wcnt;
        end
      end else begin
        case (ctl_off)
          CFG_AW'(C_LAST): seq_last_q <= cfg_wdata_i[LVL_IW-1:0];
          CFG_AW'(C_RLO):  rng_lo_q   <= cfg_wdata_i;
          CFG_AW'(C_RHI):  rng_hi_q   <= cfg_wdata_i;
          CFG_AW'(C_RCTL): begin
            rng_en_q  <= cfg_wdata_i[0];
            rng_fld_q <= rng_field_e'(cfg_wdata_i[1]);
            rng_lvl_q <= cfg_wdata_i[RNG_LVL_LSB +: LVL_IW];
          end
          CFG_AW'(C_SCTL): begin
            sto_mode_q <= sto_mode_e'(cfg_wdata_i[0]);
            sto_qual_q <= cfg_wdata_i[STO_Q_LSB +: EVT_IW];
            sto_post_q <= cfg_wdata_i[STO_N_LSB +: SCNT_W];
          end
          default: ;
        endcase
      end
    end
  end

  // event matching
  logic [N_EVT-1:0] evt_hit;
  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    bta_evt_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_cmp (
      .addr_i (smp_addr_i), .data_i (smp_data_i), .stat_i (smp_stat_i),
      .a_val_i(a_val[g]),   .a_dc_i (a_dc[g]),
      .d_val_i(d_val[g]),   .d_dc_i (d_dc[g]),
      .s_val_i(s_val[g]),   .s_dc_i (s_dc[g]),
      .en_i   (ev_en[g]),   .hit_o  (evt_hit[g])
    );
  end

  // range comparator
  logic [CFG_DW-1:0] rng_val;
  logic              in_rng;
  assign rng_val = (rng_fld_q == RNG_DATA) ? CFG_DW'(smp_data_i) : CFG_DW'(smp_addr_i);
  assign in_rng  = smp_valid_i && (rng_val >= rng_lo_q) && (rng_val <= rng_hi_q);

  // per-level hit
  logic [N_LVL-1:0] lvl_hit;
  for (genvar j = 0; j < N_LVL; j++) begin : g_lvl
    logic src, gate;
    assign src  = lvl_sel[j][EVT_IW] ? xtrig_i
                                     : (smp_valid_i & evt_hit[lvl_sel[j][EVT_IW-1:0]]);
    assign gate = (rng_en_q && (rng_lvl_q == LVL_IW'(j))) ? in_rng : 1'b1;
    assign lvl_hit[j] = src & gate;
  end

  logic fire, trig;
  bta_seq #(.N_LVL(N_LVL), .CNT_W(CNT_W), .LVL_IW(LVL_IW)) u_seq (
    .clk_i, .rst_ni, .rearm_i,
    .lvl_hit_i(lvl_hit), .lvl_cnt_i(lvl_cnt), .last_i(seq_last_q),
    .lvl_o(level_o), .trig_o(trig), .fire_o(fire), .pulse_o(xtrig_o)
  );

  logic sto_wr;
  assign sto_wr = smp_valid_i & ((sto_mode_q == STO_ALL) | evt_hit[sto_qual_q]);

  logic [ENT_W-1:0] rd_ent;
  bta_trace #(.ENT_W(ENT_W), .DEPTH(DEPTH), .TAG_W(TAG_W), .TICK_DIV(TICK_DIV),
              .PTR_W(PTR_W), .SCNT_W(SCNT_W)) u_trace (
    .clk_i, .rst_ni, .rearm_i,
    .fire_i(fire), .run_i(trig), .wr_i(sto_wr),
    .ent_i({smp_addr_i, smp_data_i, smp_stat_i}),
    .post_i(sto_post_q), .rd_idx_i,
    .rd_ent_o(rd_ent), .rd_tag_o, .cnt_o(stored_o), .done_o
  );

  assign {rd_addr_o, rd_data_o, rd_stat_o} = rd_ent;
  assign trig_o    = trig;
  assign cfg_err_o = cfg_err_q;
endmodule

// File: rtl/bus_trig_analyzer_chk.sv
module bus_trig_analyzer_chk #(
  parameter int LVL_IW = 3,
  parameter int SCNT_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rearm_i,
  input logic              trig_o,
  input logic              xtrig_o,
  input logic              done_o,
  input logic [LVL_IW-1:0] level_o,
  input logic [SCNT_W-1:0] stored_o
);
  // R4: output pulse only in first triggered cycle
  a_r4_pulse_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xtrig_o |-> (trig_o && !$past(trig_o)));
  // R4: every trigger rise drives the pulse
  a_r4_rise_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_o) |-> xtrig_o);
  // R2: level moves by at most one per cycle
  a_r2_level_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rearm_i && !trig_o) |=> ((level_o == $past(level_o)) ||
                               (level_o == LVL_IW'($past(level_o) + 1'b1))));
  // R2: level frozen once triggered
  a_r2_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o && !rearm_i) |=> $stable(level_o));
  // R7: nothing stored once done
  a_r7_stop_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !rearm_i) |=> $stable(stored_o));
  // R5: storage only while triggered
  a_r5_store_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_o && !rearm_i) |=> (stored_o == $past(stored_o)));
  // R9: re-arm clears run state
  a_r9_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (level_o == '0 && !trig_o && stored_o == '0 && !done_o));
endmodule

bind bus_trig_analyzer bus_trig_analyzer_chk #(.LVL_IW(LVL_IW), .SCNT_W(SCNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rearm_i(rearm_i), .trig_o(trig_o),
  .xtrig_o(xtrig_o), .done_o(done_o), .level_o(level_o), .stored_o(stored_o)
);

// File: tb/bus_trig_analyzer_test.sv
module bus_trig_analyzer_test;
  localparam int TAG_W = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid, xtrig_in, cfg_we, rearm;
  logic [31:0] smp_addr, smp_data, cfg_wdata;
  logic [15:0] smp_stat;
  logic [7:0]  cfg_addr, rd_idx;
  logic        trig, xtrig_out, done, cfg_err;
  logic [2:0]  level;
  logic [8:0]  stored;
  logic [31:0] rd_addr, rd_data;
  logic [15:0] rd_stat;
  logic [TAG_W-1:0] rd_tag;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bus_trig_analyzer #(.TAG_W(TAG_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_addr_i(smp_addr),
    .smp_data_i(smp_data), .smp_stat_i(smp_stat), .xtrig_i(xtrig_in),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .rearm_i(rearm), .rd_idx_i(rd_idx), .trig_o(trig), .xtrig_o(xtrig_out),
    .done_o(done), .cfg_err_o(cfg_err), .level_o(level), .stored_o(stored),
    .rd_addr_o(rd_addr), .rd_data_o(rd_data), .rd_stat_o(rd_stat), .rd_tag_o(rd_tag)
  );

  function automatic logic [7:0] ev(input int e, input int f);
    return 8'(e * 8 + f);
  endfunction
  localparam logic [7:0] LV0 = 8'h40, SEQ = 8'h48, RLO = 8'h49, RHI = 8'h4A,
                         RCTL = 8'h4B, SCTL = 8'h4C;

  // {addr, data, stat, expected trigger} against event 0
  localparam logic [80:0] VEC [5] = '{
    {32'h1000_0012, 32'hCAFE_1234, 16'h0015, 1'b1},
    {32'h1000_0112, 32'hCAFE_1234, 16'h0015, 1'b0},
    {32'h1000_0012, 32'hCAFF_0000, 16'h0015, 1'b0},
    {32'h1000_0012, 32'hCAFE_1234, 16'h0016, 1'b0},
    {32'h1000_00FF, 32'hCAFE_FFFF, 16'hABC5, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic cw(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic smp(input logic [31:0] a, input logic [31:0] d, input logic [15:0] s);
    smp_valid = 1'b1; smp_addr = a; smp_data = d; smp_stat = s;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic do_rearm();
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  task automatic rd(input int i);
    rd_idx = 8'(i);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; xtrig_in = 1'b0; cfg_we = 1'b0; rearm = 1'b0;
    smp_addr = '0; smp_data = '0; smp_stat = '0; cfg_addr = '0; cfg_wdata = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 trig", trig, 0);
    chk("R10 xtrig_o", xtrig_out, 0);
    chk("R10 done", done, 0);
    chk("R10 cfg_err", cfg_err, 0);
    chk("R10 level", level, 0);
    chk("R10 stored", stored, 0);

    // R1 comparator table on event 0, level 0 default
    cw(ev(0,0), 32'h1000_0000); cw(ev(0,1), 32'h0000_00FF);
    cw(ev(0,2), 32'hCAFE_0000); cw(ev(0,3), 32'h0000_FFFF);
    cw(ev(0,4), 32'h0000_0005); cw(ev(0,5), 32'h0000_FFF0);
    cw(ev(0,6), 32'h7);
    foreach (VEC[i]) begin
      do_rearm();
      smp(VEC[i][80:49], VEC[i][48:17], VEC[i][16:1]);
      chk($sformatf("R1 vector %0d trig", i), trig, VEC[i][0]);
    end

    // R8 zero-count level write rejected
    cw(LV0, 32'h0000_0000);
    chk("R8 err set", cfg_err, 1);
    do_rearm();
    smp(32'h1000_0012, 32'hCAFE_1234, 16'h0015);
    chk("R8 count kept at 1", trig, 1);
    cw(LV0, 32'h0000_0100);
    chk("R8 err cleared", cfg_err, 0);

    // R2 three-level sequence with count 2 in the middle
    cw(ev(1,0), 32'h100); cw(ev(1,6), 32'h1);
    cw(ev(2,0), 32'h200); cw(ev(2,6), 32'h1);
    cw(ev(3,0), 32'h300); cw(ev(3,6), 32'h1);
    cw(LV0 + 0, 32'h101); cw(LV0 + 1, 32'h202); cw(LV0 + 2, 32'h103);
    cw(SEQ, 32'd2);
    cw(SCTL, 32'h300);
    do_rearm();
    smp(32'h200, 0, 0);  chk("R2 later event ignored", level, 0);
    smp(32'h100, 0, 0);  chk("R2 level 1", level, 1);
    smp(32'h200, 0, 0);  chk("R2 count 1 of 2", level, 1);
    smp(32'h300, 0, 0);  chk("R2 wrong event", level, 1);
    smp(32'h200, 0, 0);  chk("R2 level 2", level, 2);
    chk("R2 not yet", trig, 0);
    smp(32'h300, 0, 0);
    chk("R2 triggered", trig, 1);
    chk("R4 xtrig_o pulse", xtrig_out, 1);
    chk("R5 trigger cycle not stored", stored, 0);

    // R5/R6/R7 store-all, post count 3
    for (int i = 0; i < 4; i++) begin
      smp(32'h500 + 32'(i), 32'hD0 + 32'(i), 16'(i));
      if (i == 0) chk("R4 pulse one cycle", xtrig_out, 0);
      if (i == 2) chk("R7 done at count", done, 1);
    end
    chk("R7 stored stops at 3", stored, 3);
    for (int i = 0; i < 3; i++) begin
      rd(i);
      chk($sformatf("R5 entry %0d addr", i), rd_addr, 32'h500 + 32'(i));
      chk($sformatf("R5 entry %0d data", i), rd_data, 32'hD0 + 32'(i));
      chk($sformatf("R6 entry %0d tag", i), rd_tag, (i == 2) ? 1 : 0);
    end

    // R9 re-arm
    do_rearm();
    chk("R9 trig", trig, 0);
    chk("R9 done", done, 0);
    chk("R9 stored", stored, 0);
    chk("R9 level", level, 0);

    // R6 tag at k=9 and saturation
    cw(SCTL, 32'h400);
    do_rearm();
    smp(32'h100, 0, 0); smp(32'h200, 0, 0); smp(32'h200, 0, 0); smp(32'h300, 0, 0);
    chk("R6 retrigger", trig, 1);
    repeat (9) @(negedge clk);
    smp(32'h600, 0, 0);
    repeat (600) @(negedge clk);
    smp(32'h700, 0, 0);
    rd(0); chk("R6 tag k=9", rd_tag, 4);
    rd(1); chk("R6 tag saturates", rd_tag, 8'hFF);
    chk("R6 entry addr", rd_addr, 32'h700);

    // R5 qualified storage with event 4 on status bit 0
    cw(ev(4,4), 32'h1); cw(ev(4,5), 32'hFFFE); cw(ev(4,6), 32'h4);
    cw(SCTL, 32'h241);
    cw(SEQ, 32'd0);
    do_rearm();
    smp(32'h100, 0, 0);
    chk("R5 qual trigger", trig, 1);
    smp(32'hA0, 0, 16'h0);  chk("R5 unqualified skipped", stored, 0);
    smp(32'hA1, 0, 16'h1);
    smp(32'hA2, 0, 16'h2);
    smp(32'hA3, 0, 16'h3);
    chk("R5 qualified count", stored, 2);
    chk("R7 qualified done", done, 1);
    rd(0); chk("R5 qual entry 0", rd_addr, 32'hA1);
    rd(1); chk("R5 qual entry 1", rd_addr, 32'hA3);

    // R3 address range at level 1, bounds 0x1000..0x1FFF
    cw(SCTL, 32'h1_0000);
    cw(ev(5,6), 32'h0);
    cw(LV0 + 1, 32'h105);
    cw(SEQ, 32'd1);
    cw(RLO, 32'h1000); cw(RHI, 32'h1FFF);
    cw(RCTL, 32'h11);
    do_rearm();
    smp(32'h50, 0, 0);    chk("R3 level 0 unaffected", level, 0);
    smp(32'h100, 0, 0);   chk("R3 out-of-range ok at other level", level, 1);
    smp(32'hFFF, 0, 0);   chk("R3 below low", trig, 0);
    smp(32'h2000, 0, 0);  chk("R3 above high", trig, 0);
    smp(32'h1FFF, 0, 0);  chk("R3 high bound inclusive", trig, 1);
    cw(RCTL, 32'h13);
    do_rearm();
    smp(32'h100, 0, 0);
    smp(32'h1000, 32'h5, 0);   chk("R3 data field used", trig, 0);
    smp(32'h0, 32'h1000, 0);   chk("R3 low bound inclusive", trig, 1);

    // R4 cross-trigger input as level source
    cw(RCTL, 32'h0);
    cw(LV0, 32'h108);
    cw(SEQ, 32'd0);
    do_rearm();
    smp(32'h100, 0, 0);  chk("R4 event ignored", trig, 0);
    xtrig_in = 1'b1;
    @(negedge clk);
    xtrig_in = 1'b0;
    chk("R4 xtrig_i triggers", trig, 1);
    chk("R4 xtrig_o", xtrig_out, 1);
    @(negedge clk);
    chk("R4 xtrig_o drops", xtrig_out, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule